// File: doc/BRIEF.md
# Strobed Serial B-Channel Port

This block moves one PCM byte each frame across a simple serial link. An external active-high strobe marks the slot. It repeats at 8 kHz and stays high for exactly eight bit-clock periods. The same slot carries both directions. Receive bits arrive on the serial input and are taken on the falling edges of the bit clock. Transmit bits leave on the serial output and change on the rising edges. The output enable is high only while the strobe is high, so the pin is in high impedance at all other times.

The block runs on one fast system clock. The bit clock, strobe and serial input pass through a synchronizer, and the block detects bit-clock edges from the synchronized copy. The bit clock must be 512 kHz or faster and well below the system clock. Transmit bytes are written into a holding register with a one-cycle valid pulse, and each slot sends the byte held when the slot starts. If neither transmit path is enabled, the slot carries the quiet code for the selected companding law. A received byte appears on the parallel output as soon as its slot ends, so no frame of delay is added in either direction.

Top module: `bslot_port`

## Requirements
- R1: After synchronous reset, dout_oe, rx_valid and rx_byte are all 0.
- R2: dout_oe is 0 whenever the synchronized strobe is low, and 1 throughout every strobe-high bit period.
- R3: Each slot sends its byte MSB first, one bit per bit clock, and dout changes only after a detected bit-clock rising edge.
- R4: Input bits are taken on bit-clock falling edges while the strobe is high, MSB first. After the eighth sample, rx_byte holds the byte and rx_valid pulses high for exactly one system clock.
- R5: If path_en_a and path_en_b are both 0, the slot sends the quiet code: 0xFF when law_sel is 0 (mu-law) and 0xD5 when law_sel is 1 (A-law).
- R6: If either path enable is 1, the slot sends the byte in the holding register. Writing tx_byte with tx_valid high loads that register.
- R7: There is no frame of latency. A byte written before a slot starts goes out in that slot, and the byte received in a slot is delivered before the next slot.
- R8: A strobe that drops before eight falling-edge samples gives no rx_valid. The bit count starts again at the next strobe.
- R9: A tx_valid write during a slot does not change the bits of that slot. The new byte goes out in the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock (asynchronous, slow) |
| stb | input | 1 | Active-high slot strobe |
| din | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Loads tx_byte into the holding register |
| path_en_a | input | 1 | First transmit-path enable |
| path_en_b | input | 1 | Second transmit-path enable |
| law_sel | input | 1 | Quiet-code law: 0 mu-law, 1 A-law |
| dout | output | 1 | Serial transmit data, valid while dout_oe is 1 |
| dout_oe | output | 1 | Output enable for dout (0 means high impedance) |
| rx_byte | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte updates |

## Verification
Suppose the receive bit counter is left in the wrong state after a short strobe. Then the next full slot either produces no rx_valid pulse or delivers a byte whose bits are shifted, and this is visible three system clocks after that slot's eighth falling edge. A stale slot-start flag in the transmit path shows on the first bit of a slot: the wrong byte comes out, or a byte written in the middle of a slot leaks into it. Both are seen at the first strobe-high rising edge. A wrong enable state shows at once as dout_oe high during an idle bit period.

// File: rtl/bslot_pkg.sv
package bslot_pkg;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;

  // Idle pattern for a given law, built for any slot width:
  // mu-law idles all ones; A-law idles with the top two bits set
  // and alternating ones on the even positions below them.
  function automatic logic [63:0] quiet_code(input law_e law, input int width);
    logic [63:0] q;
    q = '0;
    for (int i = 0; i < width; i++) begin
      if (law == LAW_MU)       q[i] = 1'b1;
      else if (i >= width - 2) q[i] = 1'b1;
      else                     q[i] = (i % 2 == 0);
    end
    return q;
  endfunction

endpackage

// File: rtl/bslot_sync.sv
module bslot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic stb_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic stb_o,
  output logic din_o
);
  localparam int LAST = STAGES - 1;

  // {bclk, stb, din} travel together so they stay aligned
  logic [STAGES-1:0][2:0] pipe;
  logic                   bclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe      <= '0;
      bclk_prev <= 1'b0;
    end else begin
      pipe[0] <= {bclk_i, stb_i, din_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_prev <= pipe[LAST][2];
    end
  end

  assign rise_o = pipe[LAST][2] & ~bclk_prev;
  assign fall_o = ~pipe[LAST][2] & bclk_prev;
  assign stb_o  = pipe[LAST][1];
  assign din_o  = pipe[LAST][0];

endmodule

// File: rtl/bslot_rx.sv
module bslot_rx #(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall_i,
  input  logic                 stb_i,
  input  logic                 din_i,
  output logic [SLOT_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o
);
  localparam int CW = $clog2(SLOT_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(SLOT_BITS - 1);

  logic [SLOT_BITS-1:0] shift_q;
  logic [CW-1:0]        cnt_q;
  logic [SLOT_BITS-1:0] next_word;

  assign next_word = {shift_q[SLOT_BITS-2:0], din_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!stb_i) begin
        cnt_q <= '0;
      end else if (fall_i) begin
        shift_q <= next_word;
        if (cnt_q == LAST_BIT) begin
          cnt_q      <= '0;
          rx_byte_o  <= next_word;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R4
  AST_RX_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(fall_i && stb_i)); // R4
  AST_RX_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> !rx_valid_o); // R8

endmodule

// File: rtl/bslot_tx.sv
module bslot_tx
  import bslot_pkg::*;
#(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise_i,
  input  logic                 stb_i,
  input  logic [SLOT_BITS-1:0] tx_byte_i,
  input  logic                 tx_valid_i,
  input  logic                 path_a_i,
  input  logic                 path_b_i,
  input  law_e                 law_i,
  output logic                 dout_o,
  output logic                 oe_o
);
  logic [SLOT_BITS-1:0] hold_q;
  logic [SLOT_BITS-1:0] shift_q;
  logic                 stb_seen_q;
  logic [SLOT_BITS-1:0] quiet;
  logic [SLOT_BITS-1:0] start_word;
  logic                 slot_start;

  assign quiet      = SLOT_BITS'(quiet_code(law_i, SLOT_BITS));
  assign start_word = (path_a_i | path_b_i) ? hold_q : quiet;
  assign slot_start = rise_i & stb_i & ~stb_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      shift_q    <= '0;
      stb_seen_q <= 1'b0;
      dout_o     <= 1'b0;
      oe_o       <= 1'b0;
    end else begin
      oe_o <= stb_i;
      if (tx_valid_i) hold_q <= tx_byte_i;
      if (rise_i) begin
        stb_seen_q <= stb_i;
        if (slot_start) begin
          dout_o  <= start_word[SLOT_BITS-1];
          shift_q <= start_word << 1;
        end else if (stb_i) begin
          dout_o  <= shift_q[SLOT_BITS-1];
          shift_q <= shift_q << 1;
        end
      end
    end
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> !oe_o); // R2
  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(dout_o)); // R3
  AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !path_a_i && !path_b_i) |=> dout_o == 1'b1); // R5

endmodule

// File: rtl/bslot_port.sv
module bslot_port
  import bslot_pkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk,
  input  logic                 stb,
  input  logic                 din,
  input  logic [SLOT_BITS-1:0] tx_byte,
  input  logic                 tx_valid,
  input  logic                 path_en_a,
  input  logic                 path_en_b,
  input  logic                 law_sel,
  output logic                 dout,
  output logic                 dout_oe,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  logic rise_w, fall_w, stb_w, din_w;
  law_e law_w;

  assign law_w = law_e'(law_sel);

  bslot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk), .stb_i(stb), .din_i(din),
    .rise_o(rise_w), .fall_o(fall_w), .stb_o(stb_w), .din_o(din_w)
  );

  bslot_rx #(.SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst(rst), .fall_i(fall_w), .stb_i(stb_w), .din_i(din_w),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  bslot_tx #(.SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(clk), .rst(rst), .rise_i(rise_w), .stb_i(stb_w),
    .tx_byte_i(tx_byte), .tx_valid_i(tx_valid),
    .path_a_i(path_en_a), .path_b_i(path_en_b), .law_i(law_w),
    .dout_o(dout), .oe_o(dout_oe)
  );

  AST_NO_EDGE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(rise_w)); // R4

endmodule

// File: tb/bslot_port_tb.sv
module bslot_port_tb;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0, stb = 1'b0, din = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_valid = 1'b0;
  logic       path_en_a = 1'b0, path_en_b = 1'b0, law_sel = 1'b0;
  logic       dout, dout_oe, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  bslot_port u_dut (
    .clk(clk), .rst(rst), .bclk(bclk), .stb(stb), .din(din),
    .tx_byte(tx_byte), .tx_valid(tx_valid),
    .path_en_a(path_en_a), .path_en_b(path_en_b), .law_sel(law_sel),
    .dout(dout), .dout_oe(dout_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected received bytes as rx_valid pulses (R4, R7, R8)
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected rx_valid", int'(rx_byte), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_byte == e, "R4/R7 rx_byte", int'(rx_byte), int'(e));
      end
    end
  end

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk);
    tx_byte = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic idle_bit();
    @(negedge clk);
    bclk = 1'b1; stb = 1'b0;
    repeat (HALF) @(negedge clk);
    check(dout_oe == 1'b0, "R2 oe idle", int'(dout_oe), 0);
    bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // Driver: runs one strobe of nbits; pushes the expected received byte
  task automatic run_slot(input logic [7:0] rxb, input logic [7:0] txexp, input int nbits,
                          input int upd_at, input logic [7:0] upd_val, input string req);
    if (nbits == 8) exp_q.push_back(rxb);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bclk = 1'b1; stb = 1'b1; din = rxb[7-i];
      if (i == upd_at) begin
        @(negedge clk);
        tx_byte = upd_val; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (HALF - 2) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      check(dout_oe == 1'b1, "R2 oe in slot", int'(dout_oe), 1);
      if (nbits == 8)
        check(dout == txexp[7-i], req, int'(dout), int'(txexp[7-i]));
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    idle_bit();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dout_oe == 1'b0, "R1 oe reset", int'(dout_oe), 0);
    check(rx_valid == 1'b0, "R1 rx_valid reset", int'(rx_valid), 0);
    check(rx_byte == 8'h00, "R1 rx_byte reset", int'(rx_byte), 0);
    idle_bit();

    // R6 / R7: path A, byte written just before the slot
    path_en_a = 1'b1;
    write_tx(8'h96);
    run_slot(8'h5A, 8'h96, 8, -1, 8'h00, "R3/R6/R7 tx path A");
    // R6: path B alone
    path_en_a = 1'b0; path_en_b = 1'b1;
    write_tx(8'h01);
    run_slot(8'h80, 8'h01, 8, -1, 8'h00, "R6 tx path B");
    // R5: quiet codes
    path_en_b = 1'b0; law_sel = 1'b0;
    run_slot(8'hC3, 8'hFF, 8, -1, 8'h00, "R5 quiet mu-law");
    law_sel = 1'b1;
    run_slot(8'h00, 8'hD5, 8, -1, 8'h00, "R5 quiet A-law");
    // R8: short strobe, then a full slot
    run_slot(8'hFF, 8'h00, 5, -1, 8'h00, "R8 short");
    path_en_a = 1'b1;
    write_tx(8'hE7);
    run_slot(8'h7E, 8'hE7, 8, -1, 8'h00, "R8 tx after short");
    // R9: update during a slot affects only the next slot
    write_tx(8'h3C);
    run_slot(8'hA1, 8'h3C, 8, 3, 8'hA5, "R9 tx held");
    run_slot(8'h1F, 8'hA5, 8, -1, 8'h00, "R9 tx next slot");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all bytes received", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule